// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider

This block divides a 16-bit unsigned dividend by a 16-bit unsigned divisor with a restoring shift-and-subtract loop that retires one quotient bit per clock. The results go back into the operand registers they came from. The quotient comes out on the index-register output and the remainder on the accumulator output. Three condition-flag values come out as well: zero, overflow and carry. Each flag has its own update strobe.

A pulse on `start` while the block is idle captures both operands. Sixteen iteration cycles follow, then idle padding cycles. The result therefore always appears a fixed 41 cycles after acceptance, whatever the data. `busy` covers that whole window. `done` is a single-cycle pulse, and the results, flags and strobes are valid in that same cycle. A zero divisor does not shorten the run. It raises carry and returns an all-ones quotient with the dividend left unchanged.

Top module: `idiv_seq`

## Requirements
- R1: When `done` is high, `x_out` holds the unsigned quotient floor(D/X) and `d_out` holds the remainder D mod X of the operands captured at the accepting edge, whenever X is nonzero.
- R2: A dividend smaller than a nonzero divisor gives `x_out` = 0 and `d_out` = the dividend.
- R3: In the `done` cycle, `z_flag` is 1 exactly when the remainder on `d_out` is zero.
- R4: In the `done` cycle, `v_flag` is 0.
- R5: In the `done` cycle, `c_flag` is 1 exactly when the divisor was zero. In that case `x_out` = 0xFFFF and `d_out` = the original dividend.
- R6: `done` rises 41 clock edges after the edge that accepts `start`, for every operand pair including a zero divisor. `busy` is high in the cycles between those edges and low in the `done` cycle.
- R7: A `start` pulse while `busy` is high is ignored. The running division keeps its operands and its timing.
- R8: `done` lasts one cycle. `z_upd`, `v_upd` and `c_upd` are high in that cycle and low in every other cycle.
- R9: After synchronous reset, `busy`, `done`, the strobes, the flags, `d_out` and `x_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| d_in | input | 16 | Dividend (accumulator value) |
| x_in | input | 16 | Divisor (index register value) |
| d_out | output | 16 | Remainder result |
| x_out | output | 16 | Quotient result |
| z_flag | output | 1 | Zero flag value |
| v_flag | output | 1 | Overflow flag value |
| c_flag | output | 1 | Carry flag value (divide by zero) |
| z_upd | output | 1 | Zero flag update strobe |
| v_upd | output | 1 | Overflow flag update strobe |
| c_upd | output | 1 | Carry flag update strobe |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check these rules on every cycle:
- A nonzero-divisor result leaves a remainder below the divisor.
- The zero flag agrees with the remainder output.
- A zero divisor returns all ones with the dividend intact.
- The captured operands stay fixed while busy.
- `done` is a single pulse and coincides with the fall of `busy`.

The directed scenarios are needed for the rest:
- the exact quotient values,
- the 41-edge latency counted from acceptance,
- the reset state,
- confirmation that a mid-run `start` leaves both result and timing unchanged.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    localparam int unsigned DEF_W   = 16;
    localparam int unsigned DEF_LAT = 41;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ITER = 2'd1,
        PH_PAD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/idiv_step.sv
module idiv_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    // Partial remainder shifted left with the next dividend bit brought in.
    logic [W+1:0] trial;
    logic [W-1:0] shifted;

    always_comb begin
        shifted = {rem_i[W-2:0], quo_i[W-1]};
        trial   = {1'b0, rem_i, quo_i[W-1]} - {2'b00, dvs_i};
        if (trial[W+1]) begin
            rem_o = shifted;
            quo_o = {quo_i[W-2:0], 1'b0};
        end else begin
            rem_o = trial[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/idiv_timer.sv
module idiv_timer
    import idiv_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned LAT = 41
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic iter_en,
    output logic finish,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(LAT + 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    assign accept  = (phase_q == PH_IDLE) && start;
    assign iter_en = (phase_q == PH_ITER);
    assign finish  = (phase_q == PH_PAD) && (cnt_q == CW'(LAT - 1));
    assign busy    = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_ITER;
                    cnt_q   <= '0;
                end
                PH_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(W - 1)) phase_q <= PH_PAD;
                end
                PH_PAD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(LAT - 1)) begin
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R6: busy only ends together with the completion pulse
    a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/idiv_flags.sv
module idiv_flags
    import idiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvs_i,
    output flags_t       flags_o
);
    always_comb begin
        flags_o.z = (rem_i == '0);
        flags_o.v = 1'b0;
        flags_o.c = (dvs_i == '0);
    end
endmodule

// File: rtl/idiv_seq.sv
module idiv_seq
    import idiv_pkg::*;
#(
    parameter int unsigned W   = DEF_W,
    parameter int unsigned LAT = DEF_LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] x_in,
    output logic [W-1:0] d_out,
    output logic [W-1:0] x_out,
    output logic         z_flag,
    output logic         v_flag,
    output logic         c_flag,
    output logic         z_upd,
    output logic         v_upd,
    output logic         c_upd,
    output logic         busy,
    output logic         done
);
    logic         accept, iter_en, finish;
    logic [W-1:0] rem_q, quo_q, dvs_q, num_q;
    logic [W-1:0] rem_n, quo_n, fin_rem, fin_quo;
    flags_t       flags_n, flags_q;

    idiv_timer #(.W(W), .LAT(LAT)) timer_i (
        .clk(clk), .rst(rst), .start(start), .accept(accept),
        .iter_en(iter_en), .finish(finish), .busy(busy), .done(done)
    );

    idiv_step #(.W(W)) step_i (
        .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dvs_q),
        .rem_o(rem_n), .quo_o(quo_n)
    );

    idiv_flags #(.W(W)) flags_i (
        .rem_i(fin_rem), .dvs_i(dvs_q), .flags_o(flags_n)
    );

    // Zero divisor: all-ones quotient, dividend returned untouched.
    assign fin_rem = (dvs_q == '0) ? num_q : rem_q;
    assign fin_quo = (dvs_q == '0) ? '1    : quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            num_q   <= '0;
            d_out   <= '0;
            x_out   <= '0;
            flags_q <= '0;
        end else begin
            if (accept) begin
                rem_q <= '0;
                quo_q <= d_in;
                dvs_q <= x_in;
                num_q <= d_in;
            end else if (iter_en) begin
                rem_q <= rem_n;
                quo_q <= quo_n;
            end
            if (finish) begin
                d_out   <= fin_rem;
                x_out   <= fin_quo;
                flags_q <= flags_n;
            end
        end
    end

    assign z_flag = flags_q.z;
    assign v_flag = flags_q.v;
    assign c_flag = flags_q.c;
    assign z_upd  = done;
    assign v_upd  = done;
    assign c_upd  = done;

    // R1: remainder below divisor on a normal result
    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (done && !c_flag) |-> (d_out < dvs_q));

    // R3: zero flag agrees with remainder output
    a_r3_zero_matches_rem: assert property (@(posedge clk) disable iff (rst)
        done |-> (z_flag == (d_out == '0)));

    // R5: divide by zero result pattern
    a_r5_div0_result: assert property (@(posedge clk) disable iff (rst)
        (done && c_flag) |-> ((x_out == '1) && (d_out == num_q)));

    // R7: captured operands stay fixed while a division runs
    a_r7_operands_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(dvs_q) && $stable(num_q)));
endmodule

// File: tb/idiv_seq_tb.sv
module idiv_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] d_in = '0, x_in = '0;
    logic [15:0] d_out, x_out;
    logic        z_flag, v_flag, c_flag, z_upd, v_upd, c_upd, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    idiv_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .d_in(d_in), .x_in(x_in),
        .d_out(d_out), .x_out(x_out), .z_flag(z_flag), .v_flag(v_flag),
        .c_flag(c_flag), .z_upd(z_upd), .v_upd(v_upd), .c_upd(c_upd),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Launch one division, optionally poke start mid-run; return edges to done.
    task automatic launch(input logic [15:0] d, input logic [15:0] x,
                          input bit poke, output int edges);
        @(negedge clk);
        d_in = d; x_in = x; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; d_in = 16'h5A5A; x_in = 16'h0003;
        chk("R6", "busy after accept", {31'd0, busy}, 32'd1);
        edges = 1;
        while (!done && edges < 100) begin
            if (poke && edges == 5) start = 1'b1;
            if (poke && edges == 6) start = 1'b0;
            if (z_upd || v_upd || c_upd) chk("R8", "strobe outside done", 32'd1, 32'd0);
            @(negedge clk);
            edges++;
        end
        edges--;
    endtask

    task automatic run_case(input logic [15:0] d, input logic [15:0] x, input bit poke);
        int edges;
        logic [15:0] eq, er;
        launch(d, x, poke, edges);
        if (x == 0) begin eq = 16'hFFFF; er = d; end
        else begin eq = d / x; er = d % x; end
        chk("R6", "latency", edges, 41);
        chk("R6", "busy low in done", {31'd0, busy}, 32'd0);
        chk(poke ? "R7" : (d < x ? "R2" : (x == 0 ? "R5" : "R1")), "quotient", {16'd0, x_out}, {16'd0, eq});
        chk(poke ? "R7" : (d < x ? "R2" : (x == 0 ? "R5" : "R1")), "remainder", {16'd0, d_out}, {16'd0, er});
        chk("R3", "z flag", {31'd0, z_flag}, {31'd0, er == 0});
        chk("R4", "v flag", {31'd0, v_flag}, 32'd0);
        chk("R5", "c flag", {31'd0, c_flag}, {31'd0, x == 0});
        chk("R8", "strobes in done", {29'd0, z_upd, v_upd, c_upd}, 32'd7);
        @(negedge clk);
        chk("R8", "done after pulse", {31'd0, done}, 32'd0);
        chk("R8", "strobes after pulse", {29'd0, z_upd, v_upd, c_upd}, 32'd0);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "busy/done", {30'd0, busy, done}, 32'd0);
        chk("R9", "outputs", {d_out, x_out}, 32'd0);
        chk("R9", "flags/strobes", {26'd0, z_flag, v_flag, c_flag, z_upd, v_upd, c_upd}, 32'd0);
    endtask

    task automatic test_normal();
        run_case(16'd1000, 16'd7, 1'b0);   // R1
        run_case(16'hFFFF, 16'd1, 1'b0);   // R1
        run_case(16'hFFFF, 16'hFFFF, 1'b0); // R1, R3
        run_case(16'd12, 16'd4, 1'b0);     // R3 zero remainder
        run_case(16'hFFFF, 16'h0100, 1'b0);
    endtask

    task automatic test_small_dividend();
        run_case(16'd5, 16'd300, 1'b0);    // R2
        run_case(16'd0, 16'd5, 1'b0);      // R2, R3
        run_case(16'h7FFF, 16'h8000, 1'b0); // R2
    endtask

    task automatic test_div_zero();
        run_case(16'd1234, 16'd0, 1'b0);   // R5
        run_case(16'd0, 16'd0, 1'b0);      // R5, R3
    endtask

    task automatic test_start_while_busy();
        run_case(16'd50000, 16'd9, 1'b1);  // R7
    endtask

    initial begin
        test_reset();
        test_normal();
        test_small_dividend();
        test_div_zero();
        test_start_while_busy();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule